// File: doc/BRIEF.md
# Staggered Successive-Approximation Section Sequencer

This block times a bank of identical successive-approximation converter sections that all watch the same analog input. One shared phase counter steps through a sixteen-step frame. Each section reads that counter with its own fixed delay of two clocks per section index, so the sections run the same frame shifted in time. With eight sections and a two-clock offset, exactly one section takes a sample on every second clock, and the bank as a whole converts at half the clock rate.

Inside its frame a section first samples the reference zero level, then runs an auto-zero comparison, then an auto-calibrate comparison, then samples the input. After that it spends eleven clocks on a binary search, one bit per clock from the most significant bit down, and uses the last clock to hand the result out. The comparator, the trial DAC and the analog calibration loops are not in this block. The block drives a trial word per section for the DAC, and it takes back one comparator decision bit per section. Each finished result leaves on a shared output as a one-clock pulse together with the index of the section that produced it.

Top module: `sar_interleave_seq`

## Requirements
- R1: A synchronous, active-high reset sets the shared phase to 0 and marks every section as not yet sampled. In the first clock after reset, the reference-zero strobe is 8'h01 (section 0), the auto-calibrate strobe is 8'h80 (section 7), and the sample strobe and the done pulse are both low.
- R2: The shared phase advances by one on each rising clock edge and wraps from 15 to 0, so every section's frame repeats every 16 clocks.
- R3: Section k runs at local phase (shared phase − 2·k) mod 16. Bit k of every per-section strobe vector belongs to section k.
- R4: Local phase 0 asserts the reference-zero strobe, phase 1 the auto-zero strobe, phase 2 the auto-calibrate strobe, phase 3 the sample strobe, and phase 15 the transfer strobe. A section asserts at most one strobe at a time.
- R5: On clocks where the shared phase is odd, exactly one section asserts its sample strobe. On clocks where the shared phase is even, no section asserts it.
- R6: In local phase 4+j (j = 0..10), a section's trial word (bits [11k+10:11k] of the trial bus) has bit 10−j set and every lower bit clear.
- R7: At the end of each search clock, the tested bit is kept if that section's comparator input is 1 and cleared if it is 0. The bits above the tested bit always hold the earlier decisions.
- R8: The sample clock clears the previous result, so the first trial word of every conversion is 11'h400.
- R9: At local phase 15, a section that has sampled since reset produces a one-clock done pulse, its 3-bit index and its 11-bit result. At most one done pulse is active in any clock.
- R10: A section that has not sampled since reset produces no done pulse. The first done after reset therefore comes from section 7, 13 clocks after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmp_i | input | 8 | Comparator decision per section, bit k for section k |
| zref_o | output | 8 | Reference-zero sampling strobe per section |
| azero_o | output | 8 | Auto-zero comparison strobe per section |
| acal_o | output | 8 | Auto-calibrate comparison strobe per section |
| sample_o | output | 8 | Input sample strobe per section |
| xfer_o | output | 8 | Transfer strobe per section |
| trial_o | output | 88 | Trial words, section k at bits [11k+10:11k] |
| done_o | output | 1 | One-clock result pulse |
| done_sec_o | output | 3 | Index of the section that produced the result |
| done_data_o | output | 11 | Finished 11-bit result |

## Verification
The comparator is modelled as a compare of each section's trial word against a level held at that section's sample edge, so a correct search returns exactly that level. The level table covers several cases. Zero and full scale check a comparator that always rejects or always accepts. Alternating-bit words catch bits that are swapped or dropped, and the neighbours of half scale check the MSB decision against a long carry in the lower bits. Rotating the table across sections gives every section a different level in the same window, which exposes a wrong offset or a wrong index on the done pulse. A reset in mid-conversion followed by a timed first done checks that a section which never sampled cannot emit a result.

// File: rtl/sarseq_pkg.sv
package sarseq_pkg;

    // Number of fixed steps that come before the binary search
    localparam int unsigned FIRST_SEARCH = 4;

    typedef enum logic [2:0] {
        STEP_ZREF,
        STEP_AZERO,
        STEP_ACAL,
        STEP_SAMPLE,
        STEP_SEARCH,
        STEP_XFER
    } step_e;

    // Maps a local phase to the step that the section performs in it
    function automatic step_e step_of(input int unsigned ph, input int unsigned nbits);
        step_e s;
        if (ph == 0)                          s = STEP_ZREF;
        else if (ph == 1)                     s = STEP_AZERO;
        else if (ph == 2)                     s = STEP_ACAL;
        else if (ph == 3)                     s = STEP_SAMPLE;
        else if (ph < FIRST_SEARCH + nbits)   s = STEP_SEARCH;
        else                                  s = STEP_XFER;
        return s;
    endfunction

endpackage

// File: rtl/sarseq_phase_ctr.sv
module sarseq_phase_ctr #(
    parameter int unsigned PHASES = 16,
    localparam int unsigned PW = $clog2(PHASES)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [PW-1:0] phase_o
);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (rst)
            ctr_d.cnt = '0;
        else if (ctr_q.cnt == PW'(PHASES - 1))
            ctr_d.cnt = '0;
        else
            ctr_d.cnt = ctr_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        ctr_q <= ctr_d;
    end

    assign phase_o = ctr_q.cnt;

    // R2: the frame wraps after its last phase
    assert_phase_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (phase_o == PW'(PHASES - 1)) |=> (phase_o == '0));

    // R2: any other phase steps by exactly one
    assert_phase_step_R2: assert property (@(posedge clk) disable iff (rst)
        (phase_o != PW'(PHASES - 1)) |=> (phase_o == $past(phase_o) + 1'b1));

endmodule

// File: rtl/sarseq_section.sv
module sarseq_section
    import sarseq_pkg::*;
#(
    parameter int unsigned NBITS   = 11,
    parameter int unsigned PHASES  = NBITS + FIRST_SEARCH + 1,
    parameter int unsigned STAGGER = 2,
    parameter int unsigned SEC_IDX = 0,
    localparam int unsigned PW  = $clog2(PHASES),
    localparam int unsigned BW  = $clog2(NBITS),
    localparam int unsigned OFS = (STAGGER * SEC_IDX) % PHASES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PW-1:0]    base_i,
    input  logic             cmp_i,
    output logic             zref_o,
    output logic             azero_o,
    output logic             acal_o,
    output logic             sample_o,
    output logic             xfer_o,
    output logic [NBITS-1:0] trial_o,
    output logic             done_o,
    output logic [NBITS-1:0] result_o
);

    typedef struct packed {
        logic [NBITS-1:0] result;
        logic             sampled;
    } sec_t;

    sec_t st_d, st_q;

    logic [PW:0]      sum;
    logic [PW-1:0]    lphase;
    logic [PW:0]      sbit_w;
    logic [BW-1:0]    sbit;
    logic [NBITS-1:0] onehot;
    step_e            step;

    // Local phase = shared phase delayed by this section's offset
    always_comb begin
        sum = {1'b0, base_i} + (PW+1)'(PHASES - OFS);
        if (sum >= (PW+1)'(PHASES))
            lphase = PW'(sum - (PW+1)'(PHASES));
        else
            lphase = PW'(sum);
        step   = step_of(32'(lphase), NBITS);
        sbit_w = (PW+1)'(FIRST_SEARCH + NBITS - 1) - {1'b0, lphase};
        sbit   = sbit_w[BW-1:0];
        onehot = NBITS'(1) << sbit;
    end

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.result  = '0;
            st_d.sampled = 1'b0;
        end else begin
            unique case (step)
                STEP_SAMPLE: begin
                    st_d.result  = '0;
                    st_d.sampled = 1'b1;
                end
                STEP_SEARCH: st_d.result[sbit] = cmp_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign zref_o   = (step == STEP_ZREF);
    assign azero_o  = (step == STEP_AZERO);
    assign acal_o   = (step == STEP_ACAL);
    assign sample_o = (step == STEP_SAMPLE);
    assign xfer_o   = (step == STEP_XFER);
    assign trial_o  = (step == STEP_SEARCH) ? (st_q.result | onehot) : st_q.result;
    assign done_o   = xfer_o && st_q.sampled;
    assign result_o = st_q.result;

    // R4: never more than one strobe from a section
    assert_one_step_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({zref_o, azero_o, acal_o, sample_o, xfer_o}));

    // R6: during a search clock the tested bit is set and the bits below are clear
    assert_trial_shape_R6: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_SEARCH) |-> (((trial_o & (onehot - 1'b1)) == '0) && trial_o[sbit]));

    // R7: the decision stored equals the comparator bit of the previous clock
    assert_keep_bit_R7: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_SEARCH) |=> (result_o[$past(sbit)] == $past(cmp_i)));

    // R8: each conversion opens with only the MSB set
    assert_first_trial_R8: assert property (@(posedge clk) disable iff (rst)
        sample_o |=> (trial_o == {1'b1, {(NBITS-1){1'b0}}}));

endmodule

// File: rtl/sarseq_done_mux.sv
module sarseq_done_mux #(
    parameter int unsigned NSEC  = 8,
    parameter int unsigned NBITS = 11,
    localparam int unsigned SW = $clog2(NSEC)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NSEC-1:0]       done_vec_i,
    input  logic [NSEC*NBITS-1:0] data_vec_i,
    output logic                  done_o,
    output logic [SW-1:0]         sec_o,
    output logic [NBITS-1:0]      data_o
);

    // Only one source may be active, so an OR of the gated sources is enough
    always_comb begin
        done_o = |done_vec_i;
        sec_o  = '0;
        data_o = '0;
        for (int k = 0; k < NSEC; k++) begin
            if (done_vec_i[k]) begin
                sec_o  = sec_o | SW'(k);
                data_o = data_o | data_vec_i[k*NBITS +: NBITS];
            end
        end
    end

    // R9: the staggered frames never let two sections finish together
    assert_single_done_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(done_vec_i));

endmodule

// File: rtl/sar_interleave_seq.sv
module sar_interleave_seq
    import sarseq_pkg::*;
#(
    parameter int unsigned NSEC    = 8,
    parameter int unsigned NBITS   = 11,
    parameter int unsigned STAGGER = 2,
    localparam int unsigned PHASES = NBITS + FIRST_SEARCH + 1,
    localparam int unsigned PW     = $clog2(PHASES),
    localparam int unsigned SW     = $clog2(NSEC)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NSEC-1:0]       cmp_i,
    output logic [NSEC-1:0]       zref_o,
    output logic [NSEC-1:0]       azero_o,
    output logic [NSEC-1:0]       acal_o,
    output logic [NSEC-1:0]       sample_o,
    output logic [NSEC-1:0]       xfer_o,
    output logic [NSEC*NBITS-1:0] trial_o,
    output logic                  done_o,
    output logic [SW-1:0]         done_sec_o,
    output logic [NBITS-1:0]      done_data_o
);

    logic [PW-1:0]         phase;
    logic [NSEC-1:0]       done_vec;
    logic [NSEC*NBITS-1:0] result_vec;

    sarseq_phase_ctr #(
        .PHASES (PHASES)
    ) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .phase_o (phase)
    );

    for (genvar k = 0; k < NSEC; k++) begin : g_sec
        sarseq_section #(
            .NBITS   (NBITS),
            .PHASES  (PHASES),
            .STAGGER (STAGGER),
            .SEC_IDX (k)
        ) u_sec (
            .clk      (clk),
            .rst      (rst),
            .base_i   (phase),
            .cmp_i    (cmp_i[k]),
            .zref_o   (zref_o[k]),
            .azero_o  (azero_o[k]),
            .acal_o   (acal_o[k]),
            .sample_o (sample_o[k]),
            .xfer_o   (xfer_o[k]),
            .trial_o  (trial_o[k*NBITS +: NBITS]),
            .done_o   (done_vec[k]),
            .result_o (result_vec[k*NBITS +: NBITS])
        );
    end

    sarseq_done_mux #(
        .NSEC  (NSEC),
        .NBITS (NBITS)
    ) u_mux (
        .clk        (clk),
        .rst        (rst),
        .done_vec_i (done_vec),
        .data_vec_i (result_vec),
        .done_o     (done_o),
        .sec_o      (done_sec_o),
        .data_o     (done_data_o)
    );

    // R5: a sampling clock is always followed by a quiet one
    assert_sample_gap_R5: assert property (@(posedge clk) disable iff (rst)
        (|sample_o) |=> !(|sample_o));

    // R5: a quiet clock is always followed by exactly one sampler
    assert_sample_next_R5: assert property (@(posedge clk) disable iff (rst)
        !(|sample_o) |=> $onehot(sample_o));

    // R5: never two samplers together
    assert_sample_single_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sample_o));

endmodule

// File: tb/test_sar_interleave_seq.sv
module test_sar_interleave_seq;

    localparam int CLK_PERIOD = 10;
    localparam int NSEC  = 8;
    localparam int NBITS = 11;
    localparam int NVEC  = 12;

    localparam logic [NBITS-1:0] LEVELS [NVEC] = '{
        11'h000, 11'h7FF, 11'h400, 11'h3FF, 11'h555, 11'h2AA,
        11'h001, 11'h7FE, 11'h123, 11'h6DB, 11'h0F0, 11'h50F
    };

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic [NSEC-1:0]       cmp;
    logic [NSEC-1:0]       zref, azero, acal, smp, xfer;
    logic [NSEC*NBITS-1:0] trial;
    logic                  done;
    logic [2:0]            done_sec;
    logic [NBITS-1:0]      done_data;

    logic [NBITS-1:0] target [NSEC];
    logic [NBITS-1:0] held   [NSEC];
    logic [NSEC-1:0]  msampled;
    int               mcnt;
    bit               mon_on = 1'b0;
    int               n_tests = 0;
    int               n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sar_interleave_seq i_sar_interleave_seq (
        .clk         (clk),
        .rst         (rst),
        .cmp_i       (cmp),
        .zref_o      (zref),
        .azero_o     (azero),
        .acal_o      (acal),
        .sample_o    (smp),
        .xfer_o      (xfer),
        .trial_o     (trial),
        .done_o      (done),
        .done_sec_o  (done_sec),
        .done_data_o (done_data)
    );

    function automatic int lph(input int cnt, input int k);
        return (cnt + 16 - 2*k) % 16;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Comparator model: accept a trial that does not exceed the held level
    always_comb begin
        for (int k = 0; k < NSEC; k++)
            cmp[k] = (trial[k*NBITS +: NBITS] <= held[k]);
    end

    // Independent frame model: shared counter, track-and-hold, sampled flags
    initial begin
        mcnt = 0;
        msampled = '0;
        for (int k = 0; k < NSEC; k++) begin
            held[k]   = '0;
            target[k] = '0;
        end
    end

    always @(posedge clk) begin
        if (rst) begin
            mcnt     <= 0;
            msampled <= '0;
        end else begin
            for (int k = 0; k < NSEC; k++) begin
                if (lph(mcnt, k) == 3) begin
                    held[k]     <= target[k];
                    msampled[k] <= 1'b1;
                end
            end
            mcnt <= (mcnt + 1) % 16;
        end
    end

    // Per-clock monitor
    always @(negedge clk) begin : mon
        logic [NSEC-1:0]  ez, ea, ec, es, ex;
        logic [NBITS-1:0] et, at, hm;
        bit               edone;
        int               eidx, ph, b;
        if (!rst && mon_on) begin
            ez = '0; ea = '0; ec = '0; es = '0; ex = '0;
            edone = 1'b0; eidx = 0;
            for (int k = 0; k < NSEC; k++) begin
                ph = lph(mcnt, k);
                ez[k] = (ph == 0);
                ea[k] = (ph == 1);
                ec[k] = (ph == 2);
                es[k] = (ph == 3);
                ex[k] = (ph == 15);
                if (ph == 15 && msampled[k]) begin
                    edone = 1'b1;
                    eidx  = k;
                end
                if (ph >= 4 && ph <= 14 && msampled[k]) begin
                    b  = 14 - ph;
                    hm = NBITS'(32'h7FF << (b + 1));
                    et = (held[k] & hm) | NBITS'(1 << b);
                    at = trial[k*NBITS +: NBITS];
                    if (ph == 4)
                        chk(at == et, "R8", "first trial", 32'(at), 32'(et));
                    else
                        chk(at == et, "R6 R7", "trial word", 32'(at), 32'(et));
                end
            end
            chk(zref == ez,  "R2 R3", "zref strobes",  32'(zref),  32'(ez));
            chk(azero == ea, "R3 R4", "azero strobes", 32'(azero), 32'(ea));
            chk(acal == ec,  "R3 R4", "acal strobes",  32'(acal),  32'(ec));
            chk(xfer == ex,  "R4", "xfer strobes", 32'(xfer), 32'(ex));
            chk(smp == es,   "R5", "sample strobes", 32'(smp), 32'(es));
            chk($countones(smp) == ((mcnt % 2 == 1) ? 1 : 0), "R5", "sampler count",
                32'($countones(smp)), 32'(mcnt % 2));
            chk(done == edone, "R9 R10", "done pulse", 32'(done), 32'(edone));
            if (edone) begin
                chk(done_sec == 3'(eidx), "R9", "done index", 32'(done_sec), 32'(eidx));
                chk(done_data == held[eidx], "R9", "done data",
                    32'(done_data), 32'(held[eidx]));
            end
        end
    end

    task automatic do_reset(input int n);
        @(posedge clk); #1 rst = 1'b1;
        repeat (n) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        int n;
        for (int k = 0; k < NSEC; k++) target[k] = 11'h3A5;
        do_reset(3);
        mon_on = 1'b1;

        // R1: state in the first clock after reset
        @(negedge clk);
        chk(zref == 8'h01, "R1", "reset zref", 32'(zref), 32'h01);
        chk(acal == 8'h80, "R1", "reset acal", 32'(acal), 32'h80);
        chk(smp == 8'h00,  "R1", "reset sample", 32'(smp), 32'h0);
        chk(done == 1'b0,  "R1", "reset done", 32'(done), 32'h0);

        // R10: first result after reset comes from section 7 after 13 clocks
        n = 0;
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk(n == 13, "R10", "first done delay", 32'(n), 32'd13);
        chk(done_sec == 3'd7, "R10", "first done index", 32'(done_sec), 32'd7);
        chk(done_data == 11'h3A5, "R10", "first done data", 32'(done_data), 32'h3A5);

        // Table walk: each row rotates the level set across sections
        for (int v = 0; v < NVEC; v++) begin
            @(posedge clk); #1;
            for (int k = 0; k < NSEC; k++) target[k] = LEVELS[(v + k) % NVEC];
            repeat (16) @(posedge clk);
        end
        repeat (20) @(posedge clk);

        // Reset in the middle of conversions, then run again (R1 R10)
        for (int k = 0; k < NSEC; k++) target[k] = 11'h6A9 ^ 11'(k);
        repeat (7) @(posedge clk);
        do_reset(2);
        @(negedge clk);
        chk(done == 1'b0 && zref == 8'h01, "R1", "mid-run reset",
            32'({done, zref}), 32'h01);
        repeat (48) @(posedge clk);

        @(negedge clk);
        mon_on = 1'b0;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule